// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer

This block is a watchdog timer placed behind a small CPU register bus. Software keeps the system alive by writing a fixed arming byte into one service register and then a fixed confirming byte into a second service register. Only that completed ordered pair reloads the timeout counter. If the counter runs out first, the block raises a reset-request output for a fixed number of cycles and then starts a fresh timeout period.

The bus is a single chip select, a 4-bit register offset, a write-enable level and an 8-bit write data bus. The block decodes the offset itself and acts only on write cycles. A strap input, meant to be tied by a board jumper, turns the whole timer off. While the strap is active the counter is held full, any half-finished key sequence is dropped and no reset request is produced.

Top module: `key_watchdog`

## Requirements
- R1: A bus cycle counts as a write only when `cs` and `bus_wr` are both high on a rising clock edge. The arming register sits at offset 0x8 and the confirming register at offset 0x9 of the 4-bit `addr`. A cycle with `cs` low or with `bus_wr` low changes no watchdog state.
- R2: Writing 0x55 to the arming register arms the sequence. A following write of 0xAA to the confirming register, while armed, reloads the counter. Nothing else reloads it.
- R3: After a reload, `sys_rst_req` rises exactly TIMEOUT clock cycles after the reloading edge if there is no further service. The last edge of reset counts as a reload.
- R4: Any write to the arming register with a value other than 0x55 disarms. Any write to the confirming register disarms, whatever its value. A write of 0xAA to the confirming register while unarmed does not reload.
- R5: A write to any other offset between the two key writes leaves the armed state unchanged.
- R6: On expiry, `sys_rst_req` stays high for exactly PULSE cycles. A full TIMEOUT period then restarts from the edge on which it falls.
- R7: While `wd_off` is high, `sys_rst_req` is low from the next edge on, the counter is held full and the sequence is disarmed. After release, a full TIMEOUT period runs from the last edge on which the strap was high.
- R8: A key sequence written while `sys_rst_req` is high has no effect. The pulse length and the following period are unchanged.
- R9: While `rst_n` is low, `sys_rst_req` is low from the next edge on and the sequence is disarmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs | input | 1 | Chip select for the watchdog registers |
| bus_wr | input | 1 | High for a write cycle, low for a read cycle |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| wd_off | input | 1 | Jumper strap; high disables the watchdog |
| sys_rst_req | output | 1 | Reset request, high during an expiry pulse |

## Verification
The arming byte is swept over all 256 values and the confirming byte over all 256 values, with the other byte held correct. Only the single correct value must move the expiry time, and the arithmetic expiry point tells a reload apart from a missed one. All 16 offsets are swept for the arming write, which separates correct decoding from aliasing. The service point is also slid across the whole timeout window, which shows that the period is measured from the confirming edge and not from reset. Further directed patterns check read cycles, deselected cycles, intervening foreign writes, a disarm by the strap, and service attempts during a pulse, each against a computed expiry cycle.

// File: rtl/kw_pkg.sv
// Shared types for the key-sequence watchdog.
// Assumes: a single-cycle write strobe per decoded service register.
package kw_pkg;
    // Decoded write strobes, one per service register.
    typedef struct packed {
        logic arm_wr;   // write to the arming register
        logic cfm_wr;   // write to the confirming register
    } kw_strobe_t;
endpackage

// File: rtl/kw_bus_decode.sv
// Turns a chip-select / offset / write-enable bus cycle into per-register
// write strobes. Assumes the two register offsets are different.
module kw_bus_decode #(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] ARM_OFS = 4'h8,
    parameter logic [ADDR_W-1:0] CFM_OFS = 4'h9
) (
    input  logic              cs,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] addr,
    output kw_pkg::kw_strobe_t strb
);
    localparam int NREG = 2;
    localparam logic [ADDR_W-1:0] OFS [NREG] = '{ARM_OFS, CFM_OFS};

    logic [NREG-1:0] hit;

    // One comparator per service register.
    for (genvar g = 0; g < NREG; g++) begin : g_hit
        assign hit[g] = cs && bus_wr && (addr == OFS[g]);
    end

    // Map comparator outputs onto the named strobes.
    always_comb begin
        strb.arm_wr = hit[0];
        strb.cfm_wr = hit[1];
    end
endmodule

// File: rtl/kw_key_seq.sv
// Tracks the two-byte service sequence and emits a one-cycle kick when it
// completes. Assumes `hold` is high while the timer must not be serviced.
module kw_key_seq #(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] ARM_KEY = 8'h55,
    parameter logic [DATA_W-1:0] CFM_KEY = 8'hAA
) (
    input  logic               clk,
    input  logic               rst_n,
    input  kw_pkg::kw_strobe_t strb,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               hold,
    output logic               kick
);
    logic armed;

    // Armed flag: set by a correct arming byte, dropped by any other service write.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            armed <= 1'b0;
        end else if (strb.arm_wr) begin
            armed <= (wdata == ARM_KEY);
        end else if (strb.cfm_wr) begin
            armed <= 1'b0;
        end
    end

    // Kick when the confirming byte lands while armed.
    always_comb kick = strb.cfm_wr && armed && (wdata == CFM_KEY) && !hold;

    // R4: any confirming-register write leaves the sequence disarmed.
    p_cfm_disarms_r4: assert property (@(posedge clk) disable iff (!rst_n)
        strb.cfm_wr |=> !armed);

    // R7, R8: a hold clears the sequence.
    p_hold_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !armed);
endmodule

// File: rtl/kw_timer.sv
// Timeout counter with reset-pulse generation. Counts down from
// TIMEOUT-1, raises the request for PULSE cycles on expiry, then restarts.
// Assumes TIMEOUT >= 2 and PULSE >= 1.
module kw_timer #(
    parameter int TIMEOUT = 50000,
    parameter int PULSE   = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    input  logic off,
    output logic req
);
    localparam int CNT_W = $clog2(TIMEOUT);
    localparam int PW    = $clog2(PULSE + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TIMEOUT - 1);
    localparam logic [PW-1:0]    PLAST  = PW'(PULSE - 1);

    logic [CNT_W-1:0] cnt;
    logic [PW-1:0]    pcnt;

    // Countdown, expiry pulse and restart.
    always_ff @(posedge clk) begin
        if (!rst_n || off) begin
            cnt  <= RELOAD;
            pcnt <= '0;
            req  <= 1'b0;
        end else if (req) begin
            if (pcnt == '0) begin
                req <= 1'b0;
                cnt <= RELOAD;
            end else begin
                pcnt <= pcnt - 1'b1;
            end
        end else if (kick) begin
            cnt <= RELOAD;
        end else if (cnt == '0) begin
            req  <= 1'b1;
            pcnt <= PLAST;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // R7: the strap silences the request on the next edge.
    p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        off |=> !req);

    // R3: a kick outside a pulse reloads the full period.
    p_reload_on_kick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && !req && !off) |=> (cnt == RELOAD));

    // R3: the request only rises after the counter has drained.
    p_rise_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> ($past(cnt) == '0));

    // R6: the pulse is not cut short while its counter is running.
    p_pulse_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && pcnt != '0 && !off) |=> req);
endmodule

// File: rtl/key_watchdog.sv
// Key-sequence watchdog top level: bus decode, sequence tracker, timer.
// Assumes a synchronous active-low reset and single-cycle bus writes.
module key_watchdog #(
    parameter int TIMEOUT = 50000,
    parameter int PULSE   = 64,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter logic [ADDR_W-1:0] ARM_OFS = 4'h8,
    parameter logic [ADDR_W-1:0] CFM_OFS = 4'h9,
    parameter logic [DATA_W-1:0] ARM_KEY = 8'h55,
    parameter logic [DATA_W-1:0] CFM_KEY = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wd_off,
    output logic              sys_rst_req
);
    kw_pkg::kw_strobe_t strb;
    logic kick;
    logic hold;

    // Servicing is frozen while the strap is on or a pulse is running.
    always_comb hold = wd_off || sys_rst_req;

    kw_bus_decode #(.ADDR_W(ADDR_W), .ARM_OFS(ARM_OFS), .CFM_OFS(CFM_OFS)) u_dec (
        .cs(cs), .bus_wr(bus_wr), .addr(addr), .strb(strb)
    );

    kw_key_seq #(.DATA_W(DATA_W), .ARM_KEY(ARM_KEY), .CFM_KEY(CFM_KEY)) u_seq (
        .clk(clk), .rst_n(rst_n), .strb(strb), .wdata(wdata), .hold(hold), .kick(kick)
    );

    kw_timer #(.TIMEOUT(TIMEOUT), .PULSE(PULSE)) u_tmr (
        .clk(clk), .rst_n(rst_n), .kick(kick), .off(wd_off), .req(sys_rst_req)
    );

    // R9: reset silences the request on the next edge.
    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |=> !sys_rst_req);

    // R8: no kick is accepted during a pulse.
    p_no_kick_in_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> !kick);
endmodule

// File: tb/key_watchdog_bench.sv
// Self-checking bench for key_watchdog with a small timeout and pulse.
module key_watchdog_bench;
    localparam int T = 20;
    localparam int P = 5;
    localparam logic [3:0] OA = 4'h8;
    localparam logic [3:0] OB = 4'h9;
    localparam logic [7:0] KA = 8'h55;
    localparam logic [7:0] KB = 8'hAA;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic bus_wr = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic wd_off = 1'b0;
    logic sys_rst_req;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    key_watchdog #(.TIMEOUT(T), .PULSE(P)) u_key_watchdog (
        .clk(clk), .rst_n(rst_n), .cs(cs), .bus_wr(bus_wr), .addr(addr),
        .wdata(wdata), .wd_off(wd_off), .sys_rst_req(sys_rst_req)
    );

    task automatic chk(input string rq, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Called at a negedge; one bus cycle, returns at the next negedge.
    task automatic bus_op(input logic c, input logic w, input logic [3:0] a, input logic [7:0] d);
        cs = c; bus_wr = w; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; bus_wr = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_op(1'b1, 1'b1, a, d);
    endtask

    // Reset, checking the request is low; returns at the releasing negedge.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wd_off = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 req low in reset", int'(sys_rst_req), 0);
        rst_n = 1'b1;
    endtask

    // Negedges from now until the request is seen high.
    task automatic cycles_to_rise(output int n);
        n = 0;
        while (!sys_rst_req && n < 4 * T) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Negedges from now until the request is seen low.
    task automatic cycles_to_fall(output int n);
        n = 0;
        while (sys_rst_req && n < 4 * T) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int w;

        // R3, R6: expiry from reset, pulse width, restart.
        do_reset();
        cycles_to_rise(n);
        chk("R3 expiry after reset", n, T);
        cycles_to_fall(w);
        chk("R6 pulse width", w, P);
        cycles_to_rise(n);
        chk("R6 restart period", n, T);

        // R3: slide the service point across the window.
        for (int d = 0; d <= T - 3; d++) begin
            do_reset();
            repeat (d) @(negedge clk);
            wr(OA, KA);
            wr(OB, KB);
            cycles_to_rise(n);
            chk("R3 period from confirming edge", n, T);
        end

        // R2, R4: sweep every arming byte.
        for (int v = 0; v < 256; v++) begin
            do_reset();
            wr(OA, 8'(v));
            wr(OB, KB);
            cycles_to_rise(n);
            chk("R2 arming byte sweep", n, (8'(v) == KA) ? T : T - 2);
        end

        // R2, R4: sweep every confirming byte.
        for (int v = 0; v < 256; v++) begin
            do_reset();
            wr(OA, KA);
            wr(OB, 8'(v));
            cycles_to_rise(n);
            chk("R2 confirming byte sweep", n, (8'(v) == KB) ? T : T - 2);
        end

        // R1: sweep every offset for the arming write.
        for (int a = 0; a < 16; a++) begin
            do_reset();
            wr(4'(a), KA);
            wr(OB, KB);
            cycles_to_rise(n);
            chk("R1 offset sweep", n, (4'(a) == OA) ? T : T - 2);
        end

        // R4: confirming byte without arming.
        do_reset();
        wr(OB, KB);
        cycles_to_rise(n);
        chk("R4 confirm without arm", n, T - 1);

        // R4: wrong confirming byte disarms before the right one.
        do_reset();
        wr(OA, KA);
        wr(OB, 8'h00);
        wr(OB, KB);
        cycles_to_rise(n);
        chk("R4 wrong confirm disarms", n, T - 3);

        // R4: wrong arming byte after a correct one disarms.
        do_reset();
        wr(OA, KA);
        wr(OA, 8'h54);
        wr(OB, KB);
        cycles_to_rise(n);
        chk("R4 wrong arm disarms", n, T - 3);

        // R5: foreign offset write between the keys keeps the arm.
        do_reset();
        wr(OA, KA);
        wr(4'h3, 8'hFF);
        wr(OB, KB);
        cycles_to_rise(n);
        chk("R5 foreign write keeps arm", n, T);

        // R1: read cycle to the arming offset does not arm.
        do_reset();
        bus_op(1'b1, 1'b0, OA, KA);
        wr(OB, KB);
        cycles_to_rise(n);
        chk("R1 read cycle ignored", n, T - 2);

        // R1: deselected write does not arm.
        do_reset();
        bus_op(1'b0, 1'b1, OA, KA);
        wr(OB, KB);
        cycles_to_rise(n);
        chk("R1 deselected write ignored", n, T - 2);

        // R1: read of the confirming offset does not complete the pair.
        do_reset();
        wr(OA, KA);
        bus_op(1'b1, 1'b0, OB, KB);
        cycles_to_rise(n);
        chk("R1 read of confirming offset ignored", n, T - 2);

        // R7: long strap keeps the request low, full period after release.
        do_reset();
        wd_off = 1'b1;
        w = 0;
        for (int i = 0; i < 3 * T; i++) begin
            @(negedge clk);
            if (sys_rst_req) w++;
        end
        chk("R7 no request while off", w, 0);
        wd_off = 1'b0;
        cycles_to_rise(n);
        chk("R7 full period after release", n, T);

        // R7: strap disarms a half-done sequence.
        do_reset();
        wr(OA, KA);
        wd_off = 1'b1;
        @(negedge clk);
        wd_off = 1'b0;
        wr(OB, KB);
        cycles_to_rise(n);
        chk("R7 strap disarms", n, T - 1);

        // R7: strap cuts a running pulse.
        do_reset();
        cycles_to_rise(n);
        wd_off = 1'b1;
        @(negedge clk);
        chk("R7 strap ends pulse", int'(sys_rst_req), 0);
        wd_off = 1'b0;
        cycles_to_rise(n);
        chk("R7 period after strap in pulse", n, T);

        // R8: service during a pulse is ignored.
        do_reset();
        cycles_to_rise(n);
        wr(OA, KA);
        wr(OB, KB);
        cycles_to_fall(w);
        chk("R8 pulse length unchanged", w + 2, P);
        cycles_to_rise(n);
        chk("R8 period unchanged", n, T);

        // R9: reset in mid-pulse drops the request.
        do_reset();
        cycles_to_rise(n);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset ends pulse", int'(sys_rst_req), 0);
        rst_n = 1'b1;
        cycles_to_rise(n);
        chk("R9 period after reset", n, T);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule